// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the purely combinational execute stage of a 32-bit load-store RISC core. Each cycle it receives an instruction word along with the two register operand values that the register file has already read out. It decodes the instruction and returns three things: a result, the index of the register that receives the result, and a write enable.

Two instruction shapes are handled. The first is register-register operations, whose opcode field is zero and whose operation is chosen by the function field. The second is operations with a 16-bit immediate, which are chosen by the opcode alone. The supported work is add and subtract, the four bitwise logic operations, and shifts whose amount comes either from the instruction or from a register.

A signed-overflow flag is reported but no trap is taken. Instruction codes the block does not know raise an illegal flag and cannot write. Register file, memory access, branches and multiply/divide belong to neighbouring blocks.

Top module: `risc_exec_unit`

## Requirements
- R1: With opcode bits [31:26] = 000000, function bits [5:0] select the operation. 100000 and 100001 give rs+rt. 100010 and 100011 give rs-rt. Results wrap modulo 2^32.
- R2: Function codes 100100, 100101 and 100110 give rs AND rt, rs OR rt and rs XOR rt. Function code 100111 gives the complement of (rs OR rt).
- R3: ovf_o is high for function 100000, function 100010 and opcode 001000 when the two's-complement result overflows. It is never high for any other instruction, including 100001, 100011 and opcode 001001. Overflow does not block the write.
- R4: Function codes 000000, 000010 and 000011 shift rt left, logically right (zero fill) and arithmetically right (sign fill). The amount comes from instruction bits [10:6].
- R5: Function codes 000100, 000110 and 000111 shift rt left, logically right and arithmetically right. The amount comes only from the low 5 bits of the rs operand.
- R6: Opcodes 001000 and 001001 add the sign-extended immediate from bits [15:0] to rs.
- R7: Opcodes 001100, 001101 and 001110 AND, OR and XOR rs with the zero-extended immediate.
- R8: Register-register results target bits [15:11]. Immediate results target bits [20:16].
- R9: wr_en_o is low whenever the target register index is 0.
- R10: An unknown opcode, or an unknown function code under opcode 000000, sets illegal_o high, wr_en_o low and result 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of first source register |
| rt_val_i | input | 32 | Value of second source register |
| result_o | output | 32 | Computed result |
| dest_o | output | 5 | Target register index |
| wr_en_o | output | 1 | Result should be written |
| ovf_o | output | 1 | Signed overflow detected |
| illegal_o | output | 1 | Instruction not recognised |

## Verification
The bench pushes add, sub and add-immediate across the signed boundary, and runs the unsigned forms on the same operands. A design that flagged the unsigned forms would raise a spurious overflow; one that dropped the flag would stay silent at 0x7fffffff+1.

Variable shifts are given rs operands with set high bits, so a design that used all 32 bits of rs would shift everything out. Immediates with bit 15 set catch a design that swapped sign and zero extension. Target index 0 and undefined codes check that the write enable really drops rather than writing garbage.

// File: rtl/risc_exec_unit.sv
module risc_exec_unit #(
  parameter int XLEN = 32,
  parameter int REGW = 5
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] result_o,
  output logic [REGW-1:0] dest_o,
  output logic            wr_en_o,
  output logic            ovf_o,
  output logic            illegal_o
);
  localparam int SHW = $clog2(XLEN);
  localparam int IMMW = 16;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_ADDIU = 6'b001001;
  localparam logic [5:0] OPC_ANDI  = 6'b001100;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_XORI  = 6'b001110;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;

  wire [5:0]      opc   = instr_i[31:26];
  wire [REGW-1:0] f_rt  = instr_i[20:16];
  wire [REGW-1:0] f_rd  = instr_i[15:11];
  wire [SHW-1:0]  f_sh  = instr_i[6 +: SHW];
  wire [5:0]      fn    = instr_i[5:0];
  wire [IMMW-1:0] imm   = instr_i[IMMW-1:0];
  logic unused_rs_field;
  assign unused_rs_field = ^instr_i[25:21];

  wire [XLEN-1:0] imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  wire [XLEN-1:0] imm_zx = {{(XLEN-IMMW){1'b0}}, imm};

  wire [XLEN-1:0] sum_rr  = rs_val_i + rt_val_i;
  wire [XLEN-1:0] diff_rr = rs_val_i - rt_val_i;
  wire [XLEN-1:0] sum_ri  = rs_val_i + imm_sx;
  wire [SHW-1:0]  var_amt = rs_val_i[SHW-1:0];

  wire ovf_add = (rs_val_i[XLEN-1] == rt_val_i[XLEN-1]) && (sum_rr[XLEN-1] != rs_val_i[XLEN-1]);
  wire ovf_sub = (rs_val_i[XLEN-1] != rt_val_i[XLEN-1]) && (diff_rr[XLEN-1] != rs_val_i[XLEN-1]);
  wire ovf_adi = (rs_val_i[XLEN-1] == imm_sx[XLEN-1]) && (sum_ri[XLEN-1] != rs_val_i[XLEN-1]);

  logic [XLEN-1:0] res;
  logic            legal;
  logic            to_rd;
  logic            ovf;

  always_comb begin
    res   = '0;
    legal = 1'b1;
    to_rd = 1'b1;
    ovf   = 1'b0;
    if (opc == OPC_REG) begin
      case (fn)
        FN_ADD:  begin res = sum_rr; ovf = ovf_add; end
        FN_ADDU: res = sum_rr;
        FN_SUB:  begin res = diff_rr; ovf = ovf_sub; end
        FN_SUBU: res = diff_rr;
        FN_AND:  res = rs_val_i & rt_val_i;
        FN_OR:   res = rs_val_i | rt_val_i;
        FN_XOR:  res = rs_val_i ^ rt_val_i;
        FN_NOR:  res = ~(rs_val_i | rt_val_i);
        FN_SLL:  res = rt_val_i << f_sh;
        FN_SRL:  res = rt_val_i >> f_sh;
        FN_SRA:  res = $unsigned($signed(rt_val_i) >>> f_sh);
        FN_SLLV: res = rt_val_i << var_amt;
        FN_SRLV: res = rt_val_i >> var_amt;
        FN_SRAV: res = $unsigned($signed(rt_val_i) >>> var_amt);
        default: legal = 1'b0;
      endcase
    end else begin
      to_rd = 1'b0;
      case (opc)
        OPC_ADDI:  begin res = sum_ri; ovf = ovf_adi; end
        OPC_ADDIU: res = sum_ri;
        OPC_ANDI:  res = rs_val_i & imm_zx;
        OPC_ORI:   res = rs_val_i | imm_zx;
        OPC_XORI:  res = rs_val_i ^ imm_zx;
        default:   legal = 1'b0;
      endcase
    end
  end

  assign result_o  = res;
  assign dest_o    = to_rd ? f_rd : f_rt;
  assign wr_en_o   = legal && (dest_o != '0);
  assign ovf_o     = ovf;
  assign illegal_o = !legal;

  always_comb begin
    if ((opc == OPC_ADDIU) || (opc == OPC_REG && (fn == FN_ADDU || fn == FN_SUBU)))
      assert_no_overflow_R3: assert (!ovf_o);
    if (illegal_o)
      assert_illegal_no_write_R10: assert (!wr_en_o && result_o == '0);
    if (dest_o == '0)
      assert_zero_dest_no_write_R9: assert (!wr_en_o);
    if (opc == OPC_REG && fn == FN_SRL && f_sh != '0)
      assert_srl_zero_fill_R4: assert (!result_o[XLEN-1]);
    if (opc == OPC_ANDI)
      assert_andi_upper_clear_R7: assert (result_o[XLEN-1:IMMW] == '0);
  end
endmodule

// File: tb/risc_exec_unit_tb.sv
module risc_exec_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr, a, b;
  logic [31:0] res;
  logic [4:0]  dest;
  logic        we, ovf, ill;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  risc_exec_unit u_dut (
    .instr_i(instr), .rs_val_i(a), .rt_val_i(b),
    .result_o(res), .dest_o(dest), .wr_en_o(we), .ovf_o(ovf), .illegal_o(ill)
  );

  function automatic logic [31:0] rt_enc(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] sh);
    return {6'b000000, 5'd1, 5'd2, rd, sh, fn};
  endfunction

  function automatic logic [31:0] it_enc(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
    return {op, 5'd1, rt, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    instr = i; a = x; b = y;
    #1;
  endtask

  task automatic t_reset;
    apply(32'h0, 32'h0, 32'h0);
    chk("R9 reset wr_en", {31'd0, we}, 32'd0);
    chk("R9 reset illegal", {31'd0, ill}, 32'd0);
  endtask

  task automatic t_arith;
    apply(rt_enc(6'b100000, 5'd3, 5'd0), 32'd5, 32'd7);
    chk("R1 add", res, 32'd12);
    chk("R1 add we", {31'd0, we}, 32'd1);
    apply(rt_enc(6'b100011, 5'd3, 5'd0), 32'd3, 32'd5);
    chk("R1 subu", res, 32'hffff_fffe);
    apply(rt_enc(6'b100010, 5'd3, 5'd0), 32'd3, 32'd5);
    chk("R1 sub", res, 32'hffff_fffe);
    chk("R3 sub no ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_overflow;
    apply(rt_enc(6'b100000, 5'd4, 5'd0), 32'h7fff_ffff, 32'd1);
    chk("R3 add ovf", {31'd0, ovf}, 32'd1);
    chk("R3 add ovf wraps", res, 32'h8000_0000);
    chk("R3 add ovf still writes", {31'd0, we}, 32'd1);
    apply(rt_enc(6'b100001, 5'd4, 5'd0), 32'h7fff_ffff, 32'd1);
    chk("R3 addu no ovf", {31'd0, ovf}, 32'd0);
    apply(rt_enc(6'b100010, 5'd4, 5'd0), 32'h8000_0000, 32'd1);
    chk("R3 sub ovf", {31'd0, ovf}, 32'd1);
    apply(rt_enc(6'b100011, 5'd4, 5'd0), 32'h8000_0000, 32'd1);
    chk("R3 subu no ovf", {31'd0, ovf}, 32'd0);
    apply(it_enc(6'b001000, 5'd5, 16'h0001), 32'h7fff_ffff, 32'd0);
    chk("R3 addi ovf", {31'd0, ovf}, 32'd1);
    apply(it_enc(6'b001001, 5'd5, 16'h0001), 32'h7fff_ffff, 32'd0);
    chk("R3 addiu no ovf", {31'd0, ovf}, 32'd0);
    apply(rt_enc(6'b100100, 5'd4, 5'd0), 32'h7fff_ffff, 32'h7fff_ffff);
    chk("R3 and no ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_logic;
    logic [31:0] x = 32'hf0f0_1234, y = 32'h0ff0_00ff;
    apply(rt_enc(6'b100100, 5'd6, 5'd0), x, y); chk("R2 and", res, x & y);
    apply(rt_enc(6'b100101, 5'd6, 5'd0), x, y); chk("R2 or", res, x | y);
    apply(rt_enc(6'b100110, 5'd6, 5'd0), x, y); chk("R2 xor", res, x ^ y);
    apply(rt_enc(6'b100111, 5'd6, 5'd0), x, y); chk("R2 nor", res, 32'h000f_ed00);
  endtask

  task automatic t_shift_fixed;
    apply(rt_enc(6'b000000, 5'd7, 5'd4), 32'h0, 32'h8000_0010); chk("R4 sll", res, 32'h0000_0100);
    apply(rt_enc(6'b000010, 5'd7, 5'd4), 32'h0, 32'h8000_0010); chk("R4 srl", res, 32'h0800_0001);
    apply(rt_enc(6'b000011, 5'd7, 5'd4), 32'h0, 32'h8000_0010); chk("R4 sra", res, 32'hf800_0001);
    apply(rt_enc(6'b000011, 5'd7, 5'd31), 32'h0, 32'h4000_0000); chk("R4 sra positive", res, 32'h0);
  endtask

  task automatic t_shift_var;
    apply(rt_enc(6'b000100, 5'd8, 5'd0), 32'hffff_ffe4, 32'h8000_0010); chk("R5 sllv", res, 32'h0000_0100);
    apply(rt_enc(6'b000110, 5'd8, 5'd0), 32'hffff_ffe4, 32'h8000_0010); chk("R5 srlv", res, 32'h0800_0001);
    apply(rt_enc(6'b000111, 5'd8, 5'd0), 32'h0000_0024, 32'h8000_0010); chk("R5 srav", res, 32'hf800_0001);
    apply(rt_enc(6'b000100, 5'd8, 5'd9), 32'h0000_0020, 32'h0000_0003); chk("R5 sllv ignores shamt", res, 32'h3);
  endtask

  task automatic t_imm;
    apply(it_enc(6'b001000, 5'd9, 16'hfffe), 32'd10, 32'h0); chk("R6 addi sext", res, 32'd8);
    apply(it_enc(6'b001001, 5'd9, 16'h8000), 32'd0, 32'h0); chk("R6 addiu sext", res, 32'hffff_8000);
    apply(it_enc(6'b001100, 5'd9, 16'h8001), 32'hffff_ffff, 32'h0); chk("R7 andi zext", res, 32'h0000_8001);
    apply(it_enc(6'b001101, 5'd9, 16'hffff), 32'h0, 32'h0); chk("R7 ori zext", res, 32'h0000_ffff);
    apply(it_enc(6'b001110, 5'd9, 16'hffff), 32'hffff_0000, 32'h0); chk("R7 xori zext", res, 32'hffff_ffff);
  endtask

  task automatic t_dest;
    apply(rt_enc(6'b100101, 5'd17, 5'd0), 32'h1, 32'h2);
    chk("R8 rtype dest", {27'd0, dest}, 32'd17);
    apply(it_enc(6'b001101, 5'd12, 16'h5800), 32'h0, 32'h0);
    chk("R8 itype dest", {27'd0, dest}, 32'd12);
    chk("R8 itype we", {31'd0, we}, 32'd1);
  endtask

  task automatic t_zero;
    apply(rt_enc(6'b100000, 5'd0, 5'd0), 32'd1, 32'd1);
    chk("R9 rtype r0 we", {31'd0, we}, 32'd0);
    apply(it_enc(6'b001000, 5'd0, 16'h0005), 32'd1, 32'd0);
    chk("R9 itype r0 we", {31'd0, we}, 32'd0);
  endtask

  task automatic t_illegal;
    apply(it_enc(6'b000010, 5'd3, 16'h1234), 32'd1, 32'd1);
    chk("R10 bad opcode illegal", {31'd0, ill}, 32'd1);
    chk("R10 bad opcode we", {31'd0, we}, 32'd0);
    apply(rt_enc(6'b001000, 5'd3, 5'd0), 32'd1, 32'd1);
    chk("R10 bad funct illegal", {31'd0, ill}, 32'd1);
    chk("R10 bad funct we", {31'd0, we}, 32'd0);
    chk("R10 bad funct result", res, 32'd0);
  endtask

  initial begin
    instr = '0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_arith();
    t_overflow();
    t_logic();
    t_shift_fixed();
    t_shift_var();
    t_imm();
    t_dest();
    t_zero();
    t_illegal();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule